// File: doc/BRIEF.md
# Clock Generator Configuration Bus Slave

This block is a two-wire serial slave that holds the seven configuration bytes of a clock generator. Bit fields in those bytes enable or disable individual clock outputs, and two bits choose the frequency of the two fixed-rate outputs. The host loads the bytes with a block write. The first two bytes after the address are a command code and a byte count, and both are thrown away. The host can read the bytes back in a single pass, which starts at byte 0.

SCL and SDA are oversampled by the system clock. The block never drives SCL. It drives SDA only as an open-drain pull-down, through `sda_oe`. Every transaction starts again at byte 0, and no transaction can select a byte. The power-down input releases the bus, and the configuration bytes keep their contents while it is asserted.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: Only the address byte 0xD2 (write) or 0xD3 (read) is acknowledged. Both carry the 7-bit address 0x69, and bit 0 is the read flag. Any other address gets no acknowledge, and the rest of that transaction changes no byte.
- R2: In a write, the two bytes that follow the address are acknowledged and discarded. Every later byte is stored, MSB first, into byte 0, then byte 1, and so on.
- R3: A STOP may follow any complete byte. A byte cut short by a STOP is discarded, and the bytes already stored keep their values.
- R4: In a read, byte 0 is driven, MSB first, right after the address acknowledge, followed by byte 1 and onward. A master NACK ends the transfer.
- R5: After reset, byte 0 is 0x0C: bits 3 and 2 are set, giving 48 MHz (1) rather than 24 MHz (0) for the two fixed outputs. Bytes 1 to 6 are 0xFF, and in those bytes 1 means enabled and 0 means held low.
- R6: Every byte of a write to 0xD2 is acknowledged, including bytes past byte 6. Data past byte 6 is dropped.
- R7: A read past byte 6 returns 0xFF.
- R8: While `pwr_down` is high, `sda_oe` stays low, bus activity has no effect, and all bytes keep their values. Once `pwr_down` is released, the block works again.
- R9: Every new transaction starts at byte 0.
- R10: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | High: release the bus and keep the configuration bytes |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High: pull SDA low |
| cfg_flat | output | NUM_REGS*8 | Configuration bytes, with byte n at bits [8n+7:8n] |

## Verification
The bench builds the block with its default parameters: device address 0x69, seven bytes and a two-stage synchronizer. Each SCL phase lasts eight system clocks, which is long enough for the synchronizer latency and short enough to keep runs fast. Nine-byte writes and reads drive the byte pointer to its saturated value, so the acknowledge-and-drop rule and the 0xFF read fill are both exercised. A STOP in the middle of a byte, a header-only write, a wrong address and a transaction under power-down each test the cases that must leave the bytes unchanged.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_e;

    // Synchronized line levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    // Reset value of configuration byte idx
    function automatic logic [7:0] reg_default(input int unsigned idx);
        return (idx == 0) ? 8'h0C : 8'hFF;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfg_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_last;
        logic              sda_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_sh   = {s_q.scl_sh[STAGES-2:0], scl_i};
        s_d.sda_sh   = {s_q.sda_sh[STAGES-2:0], sda_i};
        s_d.scl_last = s_q.scl_sh[STAGES-1];
        s_d.sda_last = s_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        evt.scl      = s_q.scl_sh[STAGES-1];
        evt.sda      = s_q.sda_sh[STAGES-1];
        evt.scl_rise = evt.scl && !s_q.scl_last;
        evt.scl_fall = !evt.scl && s_q.scl_last;
        evt.start    = evt.scl && s_q.scl_last && s_q.sda_last && !evt.sda;
        evt.stop     = evt.scl && s_q.scl_last && !s_q.sda_last && evt.sda;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);

    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);

    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_idx < LIMIT)) begin
            regs_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_default(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = (rd_idx < LIMIT) ? regs_q[rd_idx] : 8'hFF;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign cfg_flat[g*8 +: 8] = regs_q[g];
    end

    // R6: the write strobe never targets a byte past the bank
    p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < LIMIT));

    // R3: without a write strobe no byte moves
    p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 7,
    parameter int         PTR_W    = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  line_evt_t        evt,
    input  logic [7:0]       rd_data,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_idx
);

    localparam logic [PTR_W-1:0] LIMIT    = PTR_W'(NUM_REGS);
    localparam logic [1:0]       HDR_SKIP = 2'd2;

    typedef struct packed {
        bus_state_e       state;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic [1:0]       hdr_cnt;
        logic [PTR_W-1:0] ptr;
        logic             is_read;
        logic             drive_low;
        logic             master_nack;
    } fsm_t;

    fsm_t q, n;

    always_comb begin
        n     = q;
        wr_en = 1'b0;
        if (pwr_down) begin
            n.state     = ST_IDLE;
            n.drive_low = 1'b0;
        end else if (evt.start) begin
            n.state     = ST_ADDR;
            n.bitcnt    = 4'd0;
            n.hdr_cnt   = 2'd0;
            n.ptr       = '0;
            n.drive_low = 1'b0;
        end else if (evt.stop) begin
            n.state     = ST_IDLE;
            n.drive_low = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                end
                ST_ADDR, ST_WR_BYTE: begin
                    if (evt.scl_rise && (q.bitcnt < 4'd8)) begin
                        n.shreg  = {q.shreg[6:0], evt.sda};
                        n.bitcnt = q.bitcnt + 4'd1;
                    end else if (evt.scl_fall && (q.bitcnt == 4'd8)) begin
                        if (q.state == ST_ADDR) begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                n.state     = ST_ADDR_ACK;
                                n.drive_low = 1'b1;
                                n.is_read   = q.shreg[0];
                            end else begin
                                n.state = ST_IDLE;
                            end
                        end else begin
                            n.state     = ST_WR_ACK;
                            n.drive_low = 1'b1;
                            if (q.hdr_cnt != HDR_SKIP) begin
                                n.hdr_cnt = q.hdr_cnt + 2'd1;
                            end else if (q.ptr < LIMIT) begin
                                wr_en = 1'b1;
                                n.ptr = q.ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        n.bitcnt = 4'd0;
                        if (q.is_read) begin
                            n.state     = ST_RD_BYTE;
                            n.shreg     = rd_data;
                            n.drive_low = !rd_data[7];
                        end else begin
                            n.state     = ST_WR_BYTE;
                            n.drive_low = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (evt.scl_fall) begin
                        n.state     = ST_WR_BYTE;
                        n.bitcnt    = 4'd0;
                        n.drive_low = 1'b0;
                    end
                end
                ST_RD_BYTE: begin
                    if (evt.scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            n.state     = ST_RD_ACK;
                            n.drive_low = 1'b0;
                            if (q.ptr < LIMIT) begin
                                n.ptr = q.ptr + 1'b1;
                            end
                        end else begin
                            n.shreg     = {q.shreg[6:0], 1'b1};
                            n.drive_low = !q.shreg[6];
                            n.bitcnt    = q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) begin
                        n.master_nack = evt.sda;
                    end else if (evt.scl_fall) begin
                        if (q.master_nack) begin
                            n.state = ST_IDLE;
                        end else begin
                            n.state     = ST_RD_BYTE;
                            n.bitcnt    = 4'd0;
                            n.shreg     = rd_data;
                            n.drive_low = !rd_data[7];
                        end
                    end
                end
                default: n.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, bitcnt: 4'd0, shreg: 8'h00, hdr_cnt: 2'd0,
                   ptr: '0, is_read: 1'b0, drive_low: 1'b0, master_nack: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe  = q.drive_low && !pwr_down;
    assign wr_idx  = q.ptr;
    assign wr_data = q.shreg;
    assign rd_idx  = q.ptr;

    // R1: the address acknowledge follows only a matching address byte
    p_addr_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.state == ST_ADDR_ACK) |-> ($past(q.shreg[7:1]) == DEV_ADDR));

    // R8: power-down returns the machine to idle and blocks writes
    p_pd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (q.state == ST_IDLE));
    p_pd_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !wr_en);

    // R10: the data pull-down holds still across a high SCL phase
    p_scl_high_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.scl && $past(evt.scl) && !pwr_down && !$past(pwr_down))
            |-> $stable(sda_oe));

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_down,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_flat
);

    localparam int PTR_W = $clog2(NUM_REGS + 1);

    line_evt_t        evt;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    cfg_bus_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .evt      (evt),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx)
    );

    cfg_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cfg_flat (cfg_flat)
    );

endmodule

// File: tb/test_clkgen_cfg_slave.sv
module test_clkgen_cfg_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NREG       = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_flat;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int r10_viol = 0;
    logic [7:0] exp_regs [NREG];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_cfg_slave i_clkgen_cfg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_flat (cfg_flat)
    );

    // R10 monitor: the slave pull-down must not move while SCL stays high
    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe != oe_prev)) r10_viol++;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) begin
            check(req, $sformatf("byte %0d", i), cfg_flat[i*8 +: 8], exp_regs[i]);
        end
    endtask

    task automatic bus_wait(input int cyc);
        repeat (cyc) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; bus_wait(Q);
        sda_m = 1'b0; bus_wait(Q);
        scl_m = 1'b0; bus_wait(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; bus_wait(Q);
        scl_m = 1'b1; bus_wait(Q);
        sda_m = 1'b1; bus_wait(Q);
    endtask

    task automatic m_bit_out(input logic b);
        bus_wait(2);
        sda_m = b; bus_wait(Q);
        scl_m = 1'b1; bus_wait(Q);
        scl_m = 1'b0;
    endtask

    task automatic m_bit_in(output logic b);
        sda_m = 1'b1; bus_wait(Q + 2);
        scl_m = 1'b1; bus_wait(Q/2);
        b = sda_line; bus_wait(Q/2);
        scl_m = 1'b0;
    endtask

    task automatic m_write_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(b);
        acked = !b;
    endtask

    task automatic m_read_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            m_bit_in(b);
            v[i] = b;
        end
        m_bit_out(!give_ack);
    endtask

    // Write: address D2, two header bytes, then cnt data bytes from base value
    task automatic write_txn(input string req, input int cnt, input logic [7:0] base);
        logic ack;
        m_start();
        m_write_byte(8'hD2, ack); check(req, "addr D2 ack", ack, 1);
        m_write_byte(8'h5A, ack); check(req, "command byte ack", ack, 1);
        m_write_byte(8'h03, ack); check(req, "count byte ack", ack, 1);
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] v;
            v = base + 8'(k * 17);
            m_write_byte(v, ack);
            check(req, $sformatf("data ack %0d", k), ack, 1);
            if (k < NREG) exp_regs[k] = v;
        end
        m_stop();
    endtask

    task automatic read_txn(input string req, input int cnt);
        logic ack;
        logic [7:0] v;
        m_start();
        m_write_byte(8'hD3, ack); check(req, "addr D3 ack", ack, 1);
        for (int k = 0; k < cnt; k++) begin
            m_read_byte(k != cnt - 1, v);
            check(req, $sformatf("read byte %0d", k), v,
                  (k < NREG) ? exp_regs[k] : 8'hFF);
        end
        m_stop();
    endtask

    task automatic t_reset_state();
        check("R5", "sda_oe after reset", sda_oe, 0);
        check_bank("R5");
    endtask

    task automatic t_wrong_addr();
        logic ack;
        m_start();
        m_write_byte(8'hA4, ack); check("R1", "foreign addr nack", ack, 0);
        m_stop();
        m_start();
        m_write_byte(8'hD0, ack); check("R1", "addr D0 nack", ack, 0);
        m_write_byte(8'h00, ack);
        m_write_byte(8'h00, ack);
        m_write_byte(8'h33, ack);
        m_stop();
        check_bank("R1");
    endtask

    task automatic t_write_basic();
        write_txn("R2", 3, 8'h21);
        check_bank("R2");
    endtask

    task automatic t_read_seq();
        read_txn("R4", 4);
    endtask

    task automatic t_overrun();
        write_txn("R6", 9, 8'h10);
        check_bank("R6");
        read_txn("R7", 9);
    endtask

    task automatic t_partial();
        logic ack;
        m_start();
        m_write_byte(8'hD2, ack);
        m_write_byte(8'h00, ack);
        m_write_byte(8'h00, ack);
        m_write_byte(8'hC3, ack); check("R3", "complete byte ack", ack, 1);
        exp_regs[0] = 8'hC3;
        for (int i = 0; i < 4; i++) m_bit_out(1'b0);
        m_stop();
        check_bank("R3");
    endtask

    task automatic t_header_only();
        logic ack;
        m_start();
        m_write_byte(8'hD2, ack);
        m_write_byte(8'h77, ack);
        m_write_byte(8'h01, ack); check("R2", "header-only count ack", ack, 1);
        m_stop();
        check_bank("R2");
    endtask

    task automatic t_restart();
        write_txn("R9", 2, 8'h9C);
        check("R9", "byte 0 after new write", cfg_flat[7:0], 8'h9C);
        check_bank("R9");
    endtask

    task automatic t_powerdown();
        logic ack;
        pwr_down = 1'b1; bus_wait(4);
        m_start();
        m_write_byte(8'hD2, ack); check("R8", "no ack in power-down", ack, 0);
        m_write_byte(8'h00, ack);
        m_write_byte(8'h00, ack);
        m_write_byte(8'h44, ack);
        m_stop();
        check("R8", "sda_oe in power-down", sda_oe, 0);
        check_bank("R8");
        pwr_down = 1'b0; bus_wait(4);
        read_txn("R8", 7);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = (i == 0) ? 8'h0C : 8'hFF;
        bus_wait(5);
        rst_n = 1'b1;
        bus_wait(5);
        t_reset_state();
        t_wrong_addr();
        t_write_basic();
        t_read_seq();
        t_overrun();
        t_partial();
        t_header_only();
        t_restart();
        t_powerdown();
        check("R10", "sda_oe changes while SCL high", r10_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule